// File: doc/BRIEF.md
# Cache-Line Word Shuffle Network

This block reorders the words of one cache line before the line is spread across the data chips of a memory rank, and restores the original order when the line comes back. The reordering is keyed by the low bits of the line's column address. Consecutive lines therefore place the same logical word on different chips. A strided access that wants one word from each of several neighbouring lines can then collect all of them in a single access, with no two wanted words sitting on the same chip.

The network is a chain of log2(WORDS) conditional stages. Stage j looks at key bit j. When that bit is set, the stage splits the line into groups of 2^j words and trades every even-numbered group with the odd-numbered group next to it. The combined effect sends logical word i to physical slot i XOR key. That permutation is its own inverse, so one instance serves the write path and the read path alike. The result is captured in one register stage, and a valid flag travels with it.

Top module: `ws_shuffle`

## Requirements
- R1: The key is `in_col[log2(WORDS)-1:0]`. Column bits above the key have no effect on `out_line`.
- R2: Word p of a line occupies bits `[p*WORD_W +: WORD_W]`, with word 0 at the LSB. For an accepted line, output word p equals input word (p XOR key).
- R3: With key 0, the accepted line appears on `out_line` unchanged.
- R4: Feeding an output line back in with the same key returns the original line, for every key value.
- R5: Take any WORDS consecutive column addresses, aligned or not. A given logical word offset lands on WORDS distinct physical slots across them.
- R6: `out_valid` equals `in_valid` one clock earlier. An accepted line appears on `out_line` one clock after it is presented.
- R7: While `in_valid` is low, `out_line` holds its previous value.
- R8: Reset is synchronous and active high. It clears `out_valid` and `out_line` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input line strobe |
| in_col | input | COL_W | Column address of the line; low log2(WORDS) bits form the key |
| in_line | input | WORDS*WORD_W | Line to permute, word 0 at LSB |
| out_valid | output | 1 | Registered strobe, one clock after in_valid |
| out_line | output | WORDS*WORD_W | Registered permuted line |

## Verification
Some tests set the column bits above the key. A design that decoded too many column bits would scatter those lines differently, and these tests catch it. Single-bit keys isolate each stage. A stage that swapped groups of the wrong size, or swapped words within a group, shows up as a misplaced word at a known slot. Every key is run forward and then back through the network, and a design that used a rotation or an add instead of an XOR would fail that round trip. The distinct-slot property is checked over every aligned and unaligned window of WORDS columns, and idle cycles check that the output register holds when no line is accepted.

// File: rtl/ws_pkg.sv
package ws_pkg;
    // Physical slot of a logical word under a key: slot = word ^ key.
    function automatic int unsigned ws_slot(input int unsigned word, input int unsigned key);
        return word ^ key;
    endfunction
endpackage

// File: rtl/ws_stage.sv
module ws_stage #(
    parameter int unsigned WORDS  = 8,
    parameter int unsigned WORD_W = 64,
    parameter int unsigned LEVEL  = 0
) (
    input  logic [WORDS*WORD_W-1:0] line_i,
    input  logic                    sel_i,
    output logic [WORDS*WORD_W-1:0] line_o
);
    localparam int unsigned SPAN = 1 << LEVEL;

    // Each word trades with the word in the neighbouring group at the same offset.
    for (genvar p = 0; p < WORDS; p++) begin : g_word
        localparam int unsigned MATE = p ^ SPAN;
        assign line_o[p*WORD_W +: WORD_W] = sel_i ? line_i[MATE*WORD_W +: WORD_W]
                                                  : line_i[p*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/ws_network.sv
module ws_network #(
    parameter int unsigned WORDS  = 8,
    parameter int unsigned WORD_W = 64
) (
    input  logic [WORDS*WORD_W-1:0]  line_i,
    input  logic [$clog2(WORDS)-1:0] key_i,
    output logic [WORDS*WORD_W-1:0]  line_o
);
    localparam int unsigned KEY_W  = $clog2(WORDS);
    localparam int unsigned LINE_W = WORDS * WORD_W;

    logic [LINE_W-1:0] chain [0:KEY_W];

    assign chain[0] = line_i;

    for (genvar j = 0; j < KEY_W; j++) begin : g_level
        ws_stage #(
            .WORDS (WORDS),
            .WORD_W(WORD_W),
            .LEVEL (j)
        ) u_stage (
            .line_i(chain[j]),
            .sel_i (key_i[j]),
            .line_o(chain[j+1])
        );
    end

    assign line_o = chain[KEY_W];
endmodule

// File: rtl/ws_shuffle.sv
module ws_shuffle #(
    parameter int unsigned WORDS  = 8,
    parameter int unsigned WORD_W = 64,
    parameter int unsigned COL_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [COL_W-1:0]        in_col,
    input  logic [WORDS*WORD_W-1:0] in_line,
    output logic                    out_valid,
    output logic [WORDS*WORD_W-1:0] out_line
);
    localparam int unsigned KEY_W  = $clog2(WORDS);
    localparam int unsigned LINE_W = WORDS * WORD_W;

    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] line;
    } state_t;

    state_t            state_d, state_q;
    logic [KEY_W-1:0]  key;
    logic [LINE_W-1:0] net_line;
    logic              col_unused;

    assign key        = in_col[KEY_W-1:0];
    assign col_unused = ^in_col[COL_W-1:KEY_W];

    ws_network #(
        .WORDS (WORDS),
        .WORD_W(WORD_W)
    ) u_net (
        .line_i(in_line),
        .key_i (key),
        .line_o(net_line)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.line = net_line;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign out_line  = state_q.line;
endmodule

// File: rtl/ws_shuffle_chk.sv
module ws_shuffle_chk #(
    parameter int unsigned WORDS  = 8,
    parameter int unsigned WORD_W = 64,
    parameter int unsigned COL_W  = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [COL_W-1:0]        in_col,
    input logic [WORDS*WORD_W-1:0] in_line,
    input logic                    out_valid,
    input logic [WORDS*WORD_W-1:0] out_line
);
    import ws_pkg::*;
    localparam int unsigned KEY_W  = $clog2(WORDS);
    localparam int unsigned LINE_W = WORDS * WORD_W;

    logic             seen_q  = 1'b0;
    logic             armed_q = 1'b0;
    logic [KEY_W-1:0] key;
    logic             col_unused;

    assign key        = in_col[KEY_W-1:0];
    assign col_unused = ^in_col[COL_W-1:KEY_W];

    always_ff @(posedge clk) begin
        seen_q  <= seen_q | rst;
        armed_q <= seen_q & ~rst;
    end

    function automatic logic [WORD_W-1:0] pick(input logic [LINE_W-1:0] ln,
                                               input int unsigned idx);
        return ln[idx*WORD_W +: WORD_W];
    endfunction

    p_valid_delay_r6: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> out_valid == $past(in_valid));

    p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (seen_q && $past(rst)) |-> (!out_valid && out_line == '0));

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !$past(in_valid)) |-> $stable(out_line));

    p_zero_key_r3: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $past(in_valid) && $past(key) == '0) |-> out_line == $past(in_line));

    for (genvar k = 0; k < WORDS; k++) begin : g_map
        p_word_map_r2: assert property (@(posedge clk) disable iff (rst)
            (armed_q && $past(in_valid)) |->
            out_line[k*WORD_W +: WORD_W] ==
                pick($past(in_line), ws_slot(k, int'($past(key)))));
    end
endmodule

bind ws_shuffle ws_shuffle_chk #(
    .WORDS (WORDS),
    .WORD_W(WORD_W),
    .COL_W (COL_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_col   (in_col),
    .in_line  (in_line),
    .out_valid(out_valid),
    .out_line (out_line)
);

// File: tb/ws_shuffle_test.sv
`timescale 1ns/1ps
module ws_shuffle_test;
    localparam int unsigned WORDS  = 8;
    localparam int unsigned WORD_W = 64;
    localparam int unsigned COL_W  = 16;
    localparam int unsigned LINE_W = WORDS * WORD_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [COL_W-1:0]  in_col = '0;
    logic [LINE_W-1:0] in_line = '0;
    logic              out_valid;
    logic [LINE_W-1:0] out_line;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    ws_shuffle #(.WORDS(WORDS), .WORD_W(WORD_W), .COL_W(COL_W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_col(in_col),
        .in_line(in_line), .out_valid(out_valid), .out_line(out_line));

    function automatic logic [LINE_W-1:0] model(input logic [LINE_W-1:0] ln,
                                                input logic [COL_W-1:0] col);
        logic [LINE_W-1:0] r;
        int unsigned key;
        key = col % WORDS;
        for (int p = 0; p < WORDS; p++)
            r[p*WORD_W +: WORD_W] = ln[(p ^ key)*WORD_W +: WORD_W];
        return r;
    endfunction

    function automatic logic [LINE_W-1:0] rand_line();
        logic [LINE_W-1:0] r;
        for (int i = 0; i < LINE_W/32; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    function automatic logic [LINE_W-1:0] index_line();
        logic [LINE_W-1:0] r;
        for (int i = 0; i < WORDS; i++) r[i*WORD_W +: WORD_W] = WORD_W'(i);
        return r;
    endfunction

    task automatic step(input logic v, input logic [COL_W-1:0] c, input logic [LINE_W-1:0] l);
        @(negedge clk);
        in_valid = v;
        in_col   = c;
        in_line  = l;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_line(input string req, input logic [LINE_W-1:0] act,
                            input logic [LINE_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s line actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s bit actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    initial begin
        #(5.0 * 190000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [LINE_W-1:0] a, b, held;
        int unsigned dummy;
        dummy = $urandom(32'h5eed_0042);

        // R8: reset with a valid line on the inputs
        step(1'b1, 16'h0003, rand_line());
        step(1'b1, 16'h0005, rand_line());
        chk_bit("R8 valid in reset", out_valid, 1'b0);
        chk_line("R8 line in reset", out_line, '0);
        @(negedge clk); rst = 1'b0; in_valid = 1'b0;
        @(posedge clk); #1;
        chk_bit("R8 valid after reset", out_valid, 1'b0);
        chk_line("R8 line after reset", out_line, '0);

        // R3: key zero passes through
        a = rand_line();
        step(1'b1, 16'h0000, a);
        chk_line("R3 zero key", out_line, a);
        chk_bit("R6 valid after accept", out_valid, 1'b1);

        // R2: single-bit keys, one stage each
        for (int j = 0; j < 3; j++) begin
            a = index_line();
            step(1'b1, COL_W'(1 << j), a);
            chk_line("R2 single stage", out_line, model(a, COL_W'(1 << j)));
        end

        // R1: upper column bits ignored
        a = rand_line();
        step(1'b1, 16'hABC5, a);
        chk_line("R1 upper bits", out_line, model(a, 16'h0005));
        step(1'b1, 16'hFFF8, a);
        chk_line("R1 upper bits key0", out_line, a);

        // R6 / R7: idle cycles drop valid and hold the line
        held = out_line;
        step(1'b0, 16'h0007, rand_line());
        chk_bit("R6 valid drop", out_valid, 1'b0);
        chk_line("R7 hold", out_line, held);
        step(1'b0, 16'h0002, rand_line());
        chk_line("R7 hold again", out_line, held);

        // R4: round trip for every key
        for (int k = 0; k < WORDS; k++) begin
            a = rand_line();
            step(1'b1, COL_W'(k) | 16'h0100, a);
            b = out_line;
            step(1'b1, COL_W'(k), b);
            chk_line("R4 round trip", out_line, a);
        end

        // R5: distinct slots across every window of WORDS columns
        for (int s = 0; s < 2*WORDS; s++) begin
            logic [WORDS-1:0] seen [WORDS];
            for (int i = 0; i < WORDS; i++) seen[i] = '0;
            for (int n = 0; n < WORDS; n++) begin
                step(1'b1, COL_W'(s + n), index_line());
                for (int p = 0; p < WORDS; p++) begin
                    int unsigned lw;
                    lw = int'(out_line[p*WORD_W +: WORD_W]) % WORDS;
                    seen[lw][p] = 1'b1;
                end
            end
            for (int i = 0; i < WORDS; i++) begin
                checks++;
                if ($countones(seen[i]) != WORDS) begin
                    failures++;
                    $display("FAIL R5 window=%0d word=%0d actual_slots=%b expected=%b",
                             s, i, seen[i], {WORDS{1'b1}});
                end
            end
        end

        // R2 / R6: random mix with idle gaps
        for (int t = 0; t < 400; t++) begin
            logic v;
            logic [COL_W-1:0] c;
            v = ($urandom % 4) != 0;
            c = COL_W'($urandom);
            a = rand_line();
            held = out_line;
            step(v, c, a);
            chk_bit("R6 random valid", out_valid, v);
            if (v) chk_line("R2 random map", out_line, model(a, c));
            else   chk_line("R7 random hold", out_line, held);
        end

        // R8: reset mid-stream
        step(1'b1, 16'h0001, rand_line());
        @(negedge clk); rst = 1'b1; in_valid = 1'b1;
        @(posedge clk); #1;
        chk_bit("R8 mid reset valid", out_valid, 1'b0);
        chk_line("R8 mid reset line", out_line, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule